// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block receives configuration writes over a write-only three-wire port and holds the settings that drive a video digitiser's front end: power, output arrangement, amplifier bypass, line-counter length, clock phase, output gating, sync delay, clock source and loop-filter settings. The three port lines (active-low select, serial clock, serial data) are sampled on the block's own system clock. While select is low, every rising edge of the serial clock shifts one data bit into an 11-bit shift register, most significant bit first.

When select goes high again, the frame is checked and, if enough bits came in, the last 11 bits shifted are split into an 8-bit data byte (the first eight of those bits) and a 3-bit address (the final three). The address picks one group of control fields, and only that group is rewritten. The new values show on the outputs two system clocks after the rising edge of select is seen at the input.

The 12-bit line-counter length is too wide for one data byte, so it is written as two halves at two different addresses. All fields come out as plain level outputs, raw as stored.

Top module: `sercfg_top`

## Requirements
- R1: After reset every output is 0 (all functions on, demultiplexed output, no polarity inversion, divider code 0).
- R2: A data bit is taken only on a rising edge of `cfg_sck` while `cfg_csn` is low, most significant bit first; clock edges while `cfg_csn` is high shift nothing and count toward no frame.
- R3: Outputs change only as a result of a rising edge of `cfg_csn`, two system clocks after that edge is seen; while `cfg_csn` stays low they hold their values.
- R4: Only the last 11 bits shifted in a frame are used; any earlier bits of a longer frame have no effect.
- R5: A frame with fewer than 11 clock edges is dropped and no output changes.
- R6: Of the 11 bits used, the first eight shifted are the data byte D[7:0] (D7 first) and the last three are the address A[2:0] (A2 first).
- R7: Address 0 sets `pwr_down`=D0, `straight_mode`=D1, `amp_off`=D2, `hsync_invert`=D3, `data_hiz`=D4.
- R8: Address 1 sets `count_val[7:0]`=D[7:0] and address 2 sets `count_val[11:8]`=D[3:0]; each write leaves the other half unchanged.
- R9: Address 3 sets `clk_delay`=D[5:0]; address 4 sets `force_low`=D[5:0], bit i gating output i in the order clock, inverted clock, sync, inverted sync, converter clock A, converter clock B (1 = forced low).
- R10: Address 5 sets `sync_dly`=D[1:0] (binary: 0 to 3 clocks), `clk_ext`=D2, `in_pecl`=D3, `count_off`=D4.
- R11: Address 6 sets `cp_code`=D[1:0], `vco_high`=D2, `div_code`=D[4:3] (binary: 0 = 1/1, 1 = 1/2, 2 = 1/4, 3 = 1/8).
- R12: A write to address 7 changes no output.
- R13: One accepted frame changes at most one address group of outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_csn | input | 1 | Serial select, active low |
| cfg_sck | input | 1 | Serial bit clock |
| cfg_sdi | input | 1 | Serial data, MSB first |
| pwr_down | output | 1 | Global power-down |
| straight_mode | output | 1 | 1 = single-port output, 0 = demultiplexed |
| amp_off | output | 1 | Input amplifier bypassed |
| hsync_invert | output | 1 | Sync input polarity inverted |
| data_hiz | output | 1 | Converter data outputs high impedance |
| count_val | output | 12 | Line-counter length |
| clk_delay | output | 6 | Clock phase delay code |
| force_low | output | 6 | Per-output force-low enables |
| sync_dly | output | 2 | Sync output delay in clocks |
| clk_ext | output | 1 | 1 = external clock, 0 = oscillator |
| in_pecl | output | 1 | External clock input standard, 1 = differential |
| count_off | output | 1 | Line counter disabled |
| cp_code | output | 2 | Charge-pump current code |
| vco_high | output | 1 | High-range oscillator selected |
| div_code | output | 2 | Post-divider code |

## Verification
Every address is written with a spread of data bytes, and the line-counter halves with every possible value, so that a wrong bit position, a swapped field or one group spilling into another shows up as a mismatch on the full output vector. Frames of 16 bits with non-zero leading bits separate "keep the last 11" from "keep the first 11". Frames of 10 bits, zero bits and clock pulses given while select is high tell apart a correct edge count from one that ignores select or accepts short frames, and holding select low after a full frame shows whether the commit waits for its rising edge.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int SR_W    = 11;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = SR_W - DATA_W;
    localparam int CNT_W   = 12;
    localparam int CNT_LO_W = DATA_W;
    localparam int CNT_HI_W = CNT_W - CNT_LO_W;
    localparam int DLY_W   = 6;
    localparam int NGATE   = 6;

    localparam logic [ADDR_W-1:0] A_MISC   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_DELAY  = 3'd3;
    localparam logic [ADDR_W-1:0] A_GATE   = 3'd4;
    localparam logic [ADDR_W-1:0] A_SYNC   = 3'd5;
    localparam logic [ADDR_W-1:0] A_LOOP   = 3'd6;

    typedef struct packed {
        logic              pwr_down;
        logic              straight;
        logic              amp_off;
        logic              hs_inv;
        logic              hiz;
        logic [CNT_W-1:0]  count;
        logic [DLY_W-1:0]  delay;
        logic [NGATE-1:0]  gate;
        logic [1:0]        sync_dly;
        logic              clk_ext;
        logic              pecl;
        logic              cnt_off;
        logic [1:0]        cp;
        logic              vco_hi;
        logic [1:0]        div;
    } cfg_regs_t;

endpackage

// File: rtl/sercfg_shift.sv
module sercfg_shift #(
    parameter int SR_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csn,
    input  logic            sck,
    input  logic            sdi,
    output logic            word_vld,
    output logic [SR_W-1:0] word
);
    localparam int CW = $clog2(SR_W + 1);

    typedef struct packed {
        logic            csn;
        logic            sck;
        logic [SR_W-1:0] sr;
        logic [CW-1:0]   cnt;
        logic            vld;
        logic [SR_W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic          sck_rise;
        logic          sel_fall;
        logic          sel_rise;
        logic [CW-1:0] base;
        st_d     = st_q;
        sck_rise = sck & ~st_q.sck;
        sel_fall = ~csn & st_q.csn;
        sel_rise = csn & ~st_q.csn;
        base     = sel_fall ? '0 : st_q.cnt;
        st_d.csn = csn;
        st_d.sck = sck;
        st_d.vld = 1'b0;
        st_d.cnt = base;
        if (~csn && sck_rise) begin
            st_d.sr = {st_q.sr[SR_W-2:0], sdi};
            if (base != CW'(SR_W)) begin
                st_d.cnt = base + 1'b1;
            end
        end
        if (sel_rise) begin
            st_d.vld  = (st_q.cnt == CW'(SR_W));
            st_d.word = st_q.sr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.csn <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.word;
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
    import sercfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_vld,
    input  logic [SR_W-1:0] word,
    output cfg_regs_t       regs
);
    cfg_regs_t regs_d, regs_q;

    always_comb begin
        logic [DATA_W-1:0] dat;
        logic [ADDR_W-1:0] adr;
        regs_d = regs_q;
        dat    = word[SR_W-1:ADDR_W];
        adr    = word[ADDR_W-1:0];
        if (word_vld) begin
            case (adr)
                A_MISC: begin
                    regs_d.pwr_down = dat[0];
                    regs_d.straight = dat[1];
                    regs_d.amp_off  = dat[2];
                    regs_d.hs_inv   = dat[3];
                    regs_d.hiz      = dat[4];
                end
                A_CNT_LO: regs_d.count[CNT_LO_W-1:0]     = dat;
                A_CNT_HI: regs_d.count[CNT_W-1:CNT_LO_W] = dat[CNT_HI_W-1:0];
                A_DELAY:  regs_d.delay = dat[DLY_W-1:0];
                A_GATE:   regs_d.gate  = dat[NGATE-1:0];
                A_SYNC: begin
                    regs_d.sync_dly = dat[1:0];
                    regs_d.clk_ext  = dat[2];
                    regs_d.pecl     = dat[3];
                    regs_d.cnt_off  = dat[4];
                end
                A_LOOP: begin
                    regs_d.cp     = dat[1:0];
                    regs_d.vco_hi = dat[2];
                    regs_d.div    = dat[4:3];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/sercfg_top.sv
module sercfg_top
    import sercfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_csn,
    input  logic             cfg_sck,
    input  logic             cfg_sdi,
    output logic             pwr_down,
    output logic             straight_mode,
    output logic             amp_off,
    output logic             hsync_invert,
    output logic             data_hiz,
    output logic [CNT_W-1:0] count_val,
    output logic [DLY_W-1:0] clk_delay,
    output logic [NGATE-1:0] force_low,
    output logic [1:0]       sync_dly,
    output logic             clk_ext,
    output logic             in_pecl,
    output logic             count_off,
    output logic [1:0]       cp_code,
    output logic             vco_high,
    output logic [1:0]       div_code
);
    logic            word_vld;
    logic [SR_W-1:0] word;
    cfg_regs_t       regs;

    sercfg_shift #(.SR_W(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn      (cfg_csn),
        .sck      (cfg_sck),
        .sdi      (cfg_sdi),
        .word_vld (word_vld),
        .word     (word)
    );

    sercfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word     (word),
        .regs     (regs)
    );

    assign pwr_down      = regs.pwr_down;
    assign straight_mode = regs.straight;
    assign amp_off       = regs.amp_off;
    assign hsync_invert  = regs.hs_inv;
    assign data_hiz      = regs.hiz;
    assign count_val     = regs.count;
    assign clk_delay     = regs.delay;
    assign force_low     = regs.gate;
    assign sync_dly      = regs.sync_dly;
    assign clk_ext       = regs.clk_ext;
    assign in_pecl       = regs.pecl;
    assign count_off     = regs.cnt_off;
    assign cp_code       = regs.cp;
    assign vco_high      = regs.vco_hi;
    assign div_code      = regs.div;
endmodule

// File: rtl/sercfg_checker.sv
module sercfg_checker
    import sercfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_csn,
    input logic             pwr_down,
    input logic             straight_mode,
    input logic             amp_off,
    input logic             hsync_invert,
    input logic             data_hiz,
    input logic [CNT_W-1:0] count_val,
    input logic [DLY_W-1:0] clk_delay,
    input logic [NGATE-1:0] force_low,
    input logic [1:0]       sync_dly,
    input logic             clk_ext,
    input logic             in_pecl,
    input logic             count_off,
    input logic [1:0]       cp_code,
    input logic             vco_high,
    input logic [1:0]       div_code
);
    logic [4:0] g_misc, g_sync, g_loop;
    logic [38:0] all_bits;
    assign g_misc = {pwr_down, straight_mode, amp_off, hsync_invert, data_hiz};
    assign g_sync = {sync_dly, clk_ext, in_pecl, count_off};
    assign g_loop = {cp_code, vco_high, div_code};
    assign all_bits = {g_misc, count_val, clk_delay, force_low, g_sync, g_loop};

    // R1: first sampled cycle after reset release shows all zero
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (all_bits == '0));

    // R3: outputs move only two clocks after a rising select edge
    p_hold_outside_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(cfg_csn, 2) && !$past(cfg_csn, 3)) |-> $stable(all_bits));

    // R8: the two counter halves never change together
    p_counter_halves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((count_val[CNT_LO_W-1:0] != $past(count_val[CNT_LO_W-1:0])) &&
          (count_val[CNT_W-1:CNT_LO_W] != $past(count_val[CNT_W-1:CNT_LO_W]))));

    // R13: at most one address group changes in a cycle
    p_one_group_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({g_misc != $past(g_misc),
                    count_val[CNT_LO_W-1:0] != $past(count_val[CNT_LO_W-1:0]),
                    count_val[CNT_W-1:CNT_LO_W] != $past(count_val[CNT_W-1:CNT_LO_W]),
                    clk_delay != $past(clk_delay),
                    force_low != $past(force_low),
                    g_sync != $past(g_sync),
                    g_loop != $past(g_loop)}) <= 1);
endmodule

bind sercfg_top sercfg_checker u_sercfg_checker (.*);

// File: tb/sercfg_top_bench.sv
module sercfg_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_csn = 1'b1, cfg_sck = 1'b0, cfg_sdi = 1'b0;
    logic pwr_down, straight_mode, amp_off, hsync_invert, data_hiz;
    logic [11:0] count_val;
    logic [5:0] clk_delay, force_low;
    logic [1:0] sync_dly, cp_code, div_code;
    logic clk_ext, in_pecl, count_off, vco_high;

    int errors = 0;
    int checks = 0;
    logic [38:0] exp_v;

    always #2 clk = ~clk;

    sercfg_top u_sercfg_top (.*);

    function automatic logic [38:0] got();
        return {pwr_down, straight_mode, amp_off, hsync_invert, data_hiz, count_val,
                clk_delay, force_low, sync_dly, clk_ext, in_pecl, count_off,
                cp_code, vco_high, div_code};
    endfunction

    // Expected-state model, bit layout as got(): misc[38:34] cnt[33:22] dly[21:16]
    // gate[15:10] sync[9:5] loop[4:0]
    function automatic logic [38:0] model(logic [38:0] v, logic [10:0] w);
        logic [7:0] d = w[10:3];
        case (w[2:0])
            3'd0: v[38:34] = {d[0], d[1], d[2], d[3], d[4]};
            3'd1: v[29:22] = d;
            3'd2: v[33:30] = d[3:0];
            3'd3: v[21:16] = d[5:0];
            3'd4: v[15:10] = d[5:0];
            3'd5: v[9:5]   = {d[1:0], d[2], d[3], d[4]};
            3'd6: v[4:0]   = {d[1:0], d[2], d[4:3]};
            default: ;
        endcase
        return v;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(int n, logic [15:0] val);
        for (int i = n - 1; i >= 0; i--) begin
            cfg_sdi = val[i];
            tick(2);
            cfg_sck = 1'b1;
            tick(2);
            cfg_sck = 1'b0;
        end
    endtask

    task automatic frame(int n, logic [15:0] val);
        cfg_csn = 1'b0;
        tick(2);
        shift_bits(n, val);
        tick(2);
        cfg_csn = 1'b1;
        tick(4);
    endtask

    task automatic check(string req, logic [38:0] e);
        checks++;
        if (got() !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got(), e);
        end
    endtask

    task automatic wr(logic [7:0] d, logic [2:0] a, string req);
        frame(11, {5'd0, d, a});
        exp_v = model(exp_v, {d, a});
        check(req, exp_v);
    endtask

    initial begin
        exp_v = '0;
        tick(3);
        check("R1 reset", '0);
        rst_n = 1'b1;
        tick(3);
        check("R1 after release", '0);

        // R6 R7 R9 R10 R11 R12: sweep every address with spread data
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 256; d += 7) begin
                case (a)
                    0: wr(8'(d), 3'(a), "R7");
                    3: wr(8'(d), 3'(a), "R9 delay");
                    4: wr(8'(d), 3'(a), "R9 gate");
                    5: wr(8'(d), 3'(a), "R10");
                    6: wr(8'(d), 3'(a), "R11");
                    7: wr(8'(d), 3'(a), "R12 unused");
                    default: wr(8'(d), 3'(a), "R6");
                endcase
            end
            wr(8'hFF, 3'(a), "R6 all ones");
        end

        // R8: every counter half value
        for (int d = 0; d < 256; d++) wr(8'(d), 3'd1, "R8 low");
        for (int d = 0; d < 256; d++) wr(8'(d), 3'd2, "R8 high");

        // R4: 16-bit frames with junk leading bits
        for (int k = 0; k < 8; k++) begin
            logic [15:0] f = {5'b10110 ^ 5'(k), 8'(k * 37 + 5), 3'(k)};
            frame(16, f);
            exp_v = model(exp_v, f[10:0]);
            check("R4 long frame", exp_v);
        end

        // R5: short frames dropped
        frame(10, 16'h03FF);
        check("R5 ten bits", exp_v);
        frame(0, 16'h0000);
        check("R5 empty", exp_v);

        // R2: clock pulses while deselected do not count toward a frame
        cfg_sdi = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(2); cfg_sck = 1'b1; tick(2); cfg_sck = 1'b0;
        end
        frame(6, 16'h0021);
        check("R2 deselected clocks", exp_v);
        // R2: MSB-first order
        wr(8'b1000_0001, 3'd3, "R2 order");

        // R3: full frame with select held low does not commit
        cfg_csn = 1'b0;
        tick(2);
        shift_bits(11, {5'd0, 8'h2A, 3'd4});
        tick(6);
        check("R3 held low", exp_v);
        cfg_csn = 1'b1;
        tick(1);
        check("R3 not yet", exp_v);
        tick(3);
        exp_v = model(exp_v, {8'h2A, 3'd4});
        check("R3 committed", exp_v);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule